// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit device virtual address into a physical address by reading descriptors from a two-level translation table in memory. A request carries the virtual address and the table base register value. The walker reads the first-level descriptor. Depending on its type, it either finishes at once or reads one second-level descriptor. It then returns the physical address, the size of the mapping that was hit, or a fault.

Mappings of 1 MB (section), 64 KB (large page) and 4 KB (small page) can be mixed freely in one table. A 64 KB page appears in the second-level table as sixteen consecutive identical entries, so any of the sixteen slots resolves to the same page. The walker handles one request at a time. Memory reads go out over a request/response port with valid/ready handshakes, and results are held on a response channel until the consumer takes them.

Top module: `ptw_top`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1, and `busy_o`, `mem_req_valid_o` and `rsp_valid_o` are 0.
- R2: The first-level read address is `req_base_i + va[31:20]*4`. A walk that ends at the first level issues exactly one memory read.
- R3: A first-level descriptor whose low two bits are 2'b10 is a section. The result is `{desc[31:20], va[19:0]}`, `rsp_size_o` is 2, and bits 19:2 of the descriptor are ignored.
- R4: A first-level descriptor whose low two bits are 2'b00 or 2'b11 gives a fault with `rsp_fault_lvl_o`=0. `rsp_pa_o` and `rsp_size_o` are then 0, and only one read is issued.
- R5: A first-level descriptor whose low two bits are 2'b01 causes a second read at `{desc[31:10],10'b0} + va[19:12]*4`. Descriptor bits 9:2 do not affect that address.
- R6: A second-level descriptor whose low two bits are 2'b00 gives a fault with `rsp_fault_lvl_o`=1. `rsp_pa_o` and `rsp_size_o` are then 0.
- R7: A second-level descriptor whose low two bits are 2'b01 is a 64 KB page. The result is `{desc[31:16], va[15:0]}` and `rsp_size_o` is 1, for whichever of its sixteen replicated slots is indexed.
- R8: A second-level descriptor with bit 1 set is a 4 KB page. The result is `{desc[31:12], va[11:0]}` and `rsp_size_o` is 0.
- R9: `busy_o` is 1 and `req_ready_o` is 0 from the cycle after a request is accepted until the response handshake completes. A request offered while busy causes no read and no response.
- R10: While `rsp_ready_i` is low, the response stays valid and unchanged. While `mem_req_ready_i` is low, the memory request stays valid with the same address.
- R11: `rsp_va_o` returns the accepted virtual address. On a hit, the low 12 bits of `rsp_pa_o` equal those of the virtual address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_va_i | input | 32 | Virtual address to translate |
| req_base_i | input | 32 | First-level table base (16 KB aligned) |
| busy_o | output | 1 | Walk in progress |
| mem_req_valid_o | output | 1 | Descriptor read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Descriptor word address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Walker waiting for read data |
| mem_rsp_data_i | input | 32 | Descriptor read data |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Consumer accepts the result |
| rsp_va_o | output | 32 | Virtual address of this result |
| rsp_pa_o | output | 32 | Physical address (0 on fault) |
| rsp_size_o | output | 2 | 0: 4 KB, 1: 64 KB, 2: 1 MB |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_fault_lvl_o | output | 1 | Fault level: 0 first, 1 second |

## Verification
The assertions check the following on every cycle: the idle state is quiet, acceptance leads to busy, the memory request and the response hold steady under back-pressure, a fault carries a zero address, and a hit keeps the page offset. Only the bench scenarios can show the rest. That covers the decoding of each descriptor encoding, the exact read addresses (which decide which memory word is returned), the number of reads per walk, the equivalence of all sixteen large-page slots, and that a request offered while busy is dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW       = 32;
  localparam int SECT_SH  = 20;  // 1 MB
  localparam int LPG_SH   = 16;  // 64 KB
  localparam int SPG_SH   = 12;  // 4 KB
  localparam int L2TB_SH  = 10;  // second-level table alignment
  localparam int WORD_SH  = 2;
  localparam int L1_IDX_W = AW - SECT_SH;
  localparam int L2_IDX_W = SECT_SH - SPG_SH;

  typedef enum logic [1:0] {
    PG_SMALL = 2'd0,
    PG_LARGE = 2'd1,
    PG_SECT  = 2'd2
  } pg_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
  import ptw_pkg::*;
(
  input  logic [AW-1:0] desc_i,
  input  logic [AW-1:0] va_i,
  output logic          is_sect_o,
  output logic          is_table_o,
  output logic [AW-1:0] sect_pa_o,
  output logic [AW-1:0] l2_base_o
);
  assign is_sect_o  = (desc_i[1:0] == 2'b10);
  assign is_table_o = (desc_i[1:0] == 2'b01);
  assign sect_pa_o  = {desc_i[AW-1:SECT_SH], va_i[SECT_SH-1:0]};
  assign l2_base_o  = {desc_i[AW-1:L2TB_SH], {L2TB_SH{1'b0}}};
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
  import ptw_pkg::*;
(
  input  logic [AW-1:0] desc_i,
  input  logic [AW-1:0] va_i,
  output logic          is_fault_o,
  output pg_size_e      size_o,
  output logic [AW-1:0] pa_o
);
  logic is_small;

  assign is_small   = desc_i[1];
  assign is_fault_o = (desc_i[1:0] == 2'b00);
  assign size_o     = is_small ? PG_SMALL : PG_LARGE;
  assign pa_o       = is_small ? {desc_i[AW-1:SPG_SH], va_i[SPG_SH-1:0]}
                               : {desc_i[AW-1:LPG_SH], va_i[LPG_SH-1:0]};
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_va_i,
  input  logic [31:0]   req_base_i,
  output logic          busy_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [31:0]   mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  output logic          mem_rsp_ready_o,
  input  logic [31:0]   mem_rsp_data_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [31:0]   rsp_va_o,
  output logic [31:0]   rsp_pa_o,
  output logic [1:0]    rsp_size_o,
  output logic          rsp_fault_o,
  output logic          rsp_fault_lvl_o
);
  localparam int L1_PAD = AW - L1_IDX_W - WORD_SH;
  localparam int L2_PAD = AW - L2_IDX_W - WORD_SH;

  walk_st_e      st_q;
  logic [AW-1:0] va_q, base_q, l2_base_q, pa_q;
  pg_size_e      size_q;
  logic          fault_q, lvl_q;

  logic          l1_sect, l1_table;
  logic [AW-1:0] l1_pa, l1_next;
  logic          l2_fault;
  pg_size_e      l2_size;
  logic [AW-1:0] l2_pa;
  logic [AW-1:0] l1_off, l2_off;

  ptw_l1_dec u_l1_dec (
    .desc_i     (mem_rsp_data_i),
    .va_i       (va_q),
    .is_sect_o  (l1_sect),
    .is_table_o (l1_table),
    .sect_pa_o  (l1_pa),
    .l2_base_o  (l1_next)
  );

  ptw_l2_dec u_l2_dec (
    .desc_i     (mem_rsp_data_i),
    .va_i       (va_q),
    .is_fault_o (l2_fault),
    .size_o     (l2_size),
    .pa_o       (l2_pa)
  );

  assign l1_off = {{L1_PAD{1'b0}}, va_q[AW-1:SECT_SH], {WORD_SH{1'b0}}};
  assign l2_off = {{L2_PAD{1'b0}}, va_q[SECT_SH-1:SPG_SH], {WORD_SH{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      va_q      <= '0;
      base_q    <= '0;
      l2_base_q <= '0;
      pa_q      <= '0;
      size_q    <= PG_SMALL;
      fault_q   <= 1'b0;
      lvl_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= req_va_i;
          base_q <= req_base_i;
          st_q   <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready_i) st_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid_i) begin
          if (l1_sect) begin
            pa_q    <= l1_pa;
            size_q  <= PG_SECT;
            fault_q <= 1'b0;
            st_q    <= ST_RESP;
          end else if (l1_table) begin
            l2_base_q <= l1_next;
            st_q      <= ST_L2_REQ;
          end else begin
            pa_q    <= '0;
            size_q  <= PG_SMALL;
            fault_q <= 1'b1;
            lvl_q   <= 1'b0;
            st_q    <= ST_RESP;
          end
        end
        ST_L2_REQ: if (mem_req_ready_i) st_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid_i) begin
          if (l2_fault) begin
            pa_q    <= '0;
            size_q  <= PG_SMALL;
            fault_q <= 1'b1;
            lvl_q   <= 1'b1;
          end else begin
            pa_q    <= l2_pa;
            size_q  <= l2_size;
            fault_q <= 1'b0;
          end
          st_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign busy_o          = (st_q != ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
  assign mem_req_addr_o  = (st_q == ST_L2_REQ) ? (l2_base_q + l2_off) : (base_q + l1_off);
  assign mem_rsp_ready_o = (st_q == ST_L1_WAIT) || (st_q == ST_L2_WAIT);
  assign rsp_valid_o     = (st_q == ST_RESP);
  assign rsp_va_o        = va_q;
  assign rsp_pa_o        = pa_q;
  assign rsp_size_o      = size_q;
  assign rsp_fault_o     = fault_q;
  assign rsp_fault_lvl_o = lvl_q;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_valid_o && !rsp_valid_o));

  p_accept_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (busy_o && !req_ready_o));

  p_memreq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  p_rsp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_size_o) && $stable(rsp_fault_o)));

  p_fault_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_o == '0 && rsp_size_o == 2'd0));

  p_page_offset_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_pa_o[SPG_SH-1:0] == rsp_va_o[SPG_SH-1:0]));
endmodule

// File: tb/ptw_top_tb_top.sv
module ptw_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 50000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_va_i = '0;
  logic [31:0] req_base_i = '0;
  logic        busy_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i;
  logic        mem_rsp_ready_o;
  logic [31:0] mem_rsp_data_i;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b1;
  logic [31:0] rsp_va_o;
  logic [31:0] rsp_pa_o;
  logic [1:0]  rsp_size_o;
  logic        rsp_fault_o;
  logic        rsp_fault_lvl_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ptw_top dut_i (.*);

  // memory model: sparse descriptor store, one-cycle read latency
  logic [31:0] mem [logic [31:0]];
  logic        stall_en = 1'b0;
  logic        tgl;
  int          rd_cnt;
  int          cyc;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  assign mem_req_ready_i = !stall_en || tgl;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rsp_valid_i <= 1'b0;
      mem_rsp_data_i  <= '0;
      tgl             <= 1'b0;
      rd_cnt          <= 0;
    end else begin
      tgl             <= ~tgl;
      mem_rsp_valid_i <= mem_req_valid_o && mem_req_ready_i;
      mem_rsp_data_i  <= rd(mem_req_addr_o);
      if (mem_req_valid_o && mem_req_ready_i) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_CYC && !done) begin
      n_bad++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] base;
    logic [31:0] pa;
    logic [1:0]  sz;
    logic        flt;
    logic        lvl;
    logic [1:0]  nrd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h0012_3456, 32'h0001_0000, 32'h8012_3456, 2'd2, 1'b0, 1'b0, 2'd1, 4'd3},  // R3
    '{32'h0050_0001, 32'h0001_0000, 32'h9000_0001, 2'd2, 1'b0, 1'b0, 2'd1, 4'd3},  // R3 junk bits
    '{32'hFFFF_FFFF, 32'h0001_0000, 32'hABCF_FFFF, 2'd2, 1'b0, 1'b0, 2'd1, 4'd2},  // R2 last slot
    '{32'h0030_0000, 32'h0001_0000, 32'h0000_0000, 2'd0, 1'b1, 1'b0, 2'd1, 4'd4},  // R4 00
    '{32'h0040_0ABC, 32'h0001_0000, 32'h0000_0000, 2'd0, 1'b1, 1'b0, 2'd1, 4'd4},  // R4 11
    '{32'h0020_5ABC, 32'h0001_0000, 32'h1234_5ABC, 2'd0, 1'b0, 1'b0, 2'd2, 4'd8},  // R8
    '{32'h0020_6111, 32'h0001_0000, 32'h2222_2111, 2'd0, 1'b0, 1'b0, 2'd2, 4'd8},  // R8 low 11
    '{32'h0021_789A, 32'h0001_0000, 32'h4444_789A, 2'd1, 1'b0, 1'b0, 2'd2, 4'd7},  // R7
    '{32'h0021_0000, 32'h0001_0000, 32'h4444_0000, 2'd1, 1'b0, 1'b0, 2'd2, 4'd7},  // R7 first slot
    '{32'h0021_FFFF, 32'h0001_0000, 32'h4444_FFFF, 2'd1, 1'b0, 1'b0, 2'd2, 4'd7},  // R7 last slot
    '{32'h0020_0123, 32'h0001_0000, 32'h0000_0000, 2'd0, 1'b1, 1'b1, 2'd2, 4'd6},  // R6 empty
    '{32'h0020_1000, 32'h0001_0000, 32'h0000_0000, 2'd0, 1'b1, 1'b1, 2'd2, 4'd6},  // R6 junk bits
    '{32'h0012_3456, 32'h0004_0000, 32'h0000_0000, 2'd0, 1'b1, 1'b0, 2'd1, 4'd2},  // R2 other base
    '{32'h0020_5ABC, 32'h0004_0000, 32'h6666_6ABC, 2'd0, 1'b0, 1'b0, 2'd2, 4'd5}   // R5 bits 9:2 set
  };

  logic [31:0] o_pa, o_va;
  logic [1:0]  o_sz;
  logic        o_flt, o_lvl;
  int          o_nrd;

  task automatic walk(input logic [31:0] va, input logic [31:0] base);
    int c0;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    c0 = rd_cnt;
    req_valid_i = 1'b1;
    req_va_i    = va;
    req_base_i  = base;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!rsp_valid_o) @(negedge clk_i);
    o_pa  = rsp_pa_o;
    o_va  = rsp_va_o;
    o_sz  = rsp_size_o;
    o_flt = rsp_fault_o;
    o_lvl = rsp_fault_lvl_o;
    o_nrd = rd_cnt - c0;
  endtask

  initial begin
    mem[32'h0001_0004] = 32'h8010_0002;  // section
    mem[32'h0001_0014] = 32'h900F_FFFE;  // section, middle bits set
    mem[32'h0001_3FFC] = 32'hABC0_0002;  // section, last slot
    mem[32'h0001_0010] = 32'h5555_0003;  // fault type 11
    mem[32'h0001_0008] = 32'h0002_0401;  // table at 0x0002_0400
    mem[32'h0002_0414] = 32'h1234_5002;
    mem[32'h0002_0418] = 32'h2222_2003;
    mem[32'h0002_0404] = 32'h7777_7FFC;  // L2 fault, upper bits set
    for (int i = 0; i < 16; i++) mem[32'h0002_0440 + 32'(i*4)] = 32'h4444_0001;
    mem[32'h0004_0008] = 32'h0003_03FD;  // table at 0x0003_0000
    mem[32'h0003_0014] = 32'h6666_6002;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 req_ready", 32'(req_ready_o), 32'd1);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 mem_req_valid", 32'(mem_req_valid_o), 32'd0);
    chk("R1 rsp_valid", 32'(rsp_valid_o), 32'd0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[v].rq, v);
      walk(VEC[v].va, VEC[v].base);
      chk({tag, " pa"}, o_pa, VEC[v].pa);
      chk({tag, " size"}, 32'(o_sz), 32'(VEC[v].sz));
      chk({tag, " fault"}, 32'(o_flt), 32'(VEC[v].flt));
      if (VEC[v].flt) chk({tag, " level"}, 32'(o_lvl), 32'(VEC[v].lvl));
      chk({tag, " reads"}, 32'(o_nrd), 32'(VEC[v].nrd));
      chk({tag, " R11 va"}, o_va, VEC[v].va);
    end

    // R10 memory back-pressure on a two-read walk
    stall_en = 1'b1;
    walk(32'h0021_3456, 32'h0001_0000);
    chk("R10 stall pa", o_pa, 32'h4444_3456);
    chk("R10 stall reads", 32'(o_nrd), 32'd2);
    stall_en = 1'b0;

    // R9/R10 response back-pressure; a request offered while busy is dropped
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    walk(32'h0020_6111, 32'h0001_0000);
    begin
      int c1;
      c1 = rd_cnt;
      req_valid_i = 1'b1;
      req_va_i    = 32'h0012_3456;
      req_base_i  = 32'h0001_0000;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk_i);
        chk("R10 rsp held valid", 32'(rsp_valid_o), 32'd1);
        chk("R10 rsp pa stable", rsp_pa_o, 32'h2222_2111);
        chk("R9 busy held", 32'(busy_o), 32'd1);
        chk("R9 not ready", 32'(req_ready_o), 32'd0);
      end
      req_valid_i = 1'b0;
      rsp_ready_i = 1'b1;
      @(negedge clk_i);
      chk("R9 idle after handshake", 32'(busy_o), 32'd0);
      chk("R9 no rsp after handshake", 32'(rsp_valid_o), 32'd0);
      repeat (4) @(negedge clk_i);
      chk("R9 busy request ignored reads", 32'(rd_cnt - c1), 32'd0);
      chk("R9 busy request ignored rsp", 32'(rsp_valid_o), 32'd0);
    end

    // R11 offset on a fresh hit after the above
    walk(32'h0050_0ABC, 32'h0001_0000);
    chk("R11 offset", o_pa, 32'h9000_0ABC);
    @(negedge clk_i);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial cyc = 0;
endmodule